// File: doc/BRIEF.md
# RMII MAC-Side Dibit Interface

This block sits between a byte-oriented Ethernet MAC and a PHY attached over the Reduced Media Independent Interface. Its transmit half takes frame bytes from the MAC with a valid/ready handshake and start/end markers. It sends each byte to the PHY as four two-bit symbols, lowest pair first, while holding the transmit enable high for the whole frame without gaps.

Its receive half watches the PHY's combined carrier/data-valid line. It collects the two-bit symbols that arrive with no receive error and rebuilds bytes from them. When the carrier line drops it emits an end-of-frame pulse. That pulse carries a flag if a receive error was seen during the frame, and a second flag if the frame stopped partway through a byte.

Both halves run on the single continuous 50 MHz reference clock. Preamble, frame check sequence and 10 Mb/s symbol replication are handled elsewhere.

Top module: `rmii_dibit_if`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), phy_tx_en, phy_txd, rx_valid, rx_sof, rx_eof, rx_frame_err and rx_align_err are 0, and tx_ready is 1.
- R2: Each transmitted byte appears on phy_txd as four consecutive symbols: bits [1:0] first, then [3:2], [5:4] and [7:6].
- R3: A frame of N bytes holds phy_tx_en high for exactly 4N consecutive clocks. The first of these clocks is the one that follows the edge at which the start byte is taken.
- R4: tx_ready is 1 while no frame is being sent. Inside a frame, each further byte is taken exactly 4 clocks after the previous one.
- R5: phy_txd is 00 whenever phy_tx_en is 0.
- R6: When no frame is active, a byte offered without tx_sof is consumed and discarded, and no frame starts.
- R7: If, on the last symbol of a byte that is not marked tx_eof, no byte is offered, the frame ends after that byte.
- R8: A symbol counts only when phy_carrier_dv is 1 and phy_rx_err is 0. Four counted symbols form rx_data, the first one landing in bits [1:0]. rx_valid is a one-clock pulse, and rx_sof is 1 with the first byte of a frame only.
- R9: rx_eof is a single one-clock pulse in the clock after the edge at which phy_carrier_dv is first sampled 0 following a frame.
- R10: rx_frame_err is 1 with rx_eof if phy_rx_err was 1 at any sampled edge while phy_carrier_dv was 1 in that frame, and 0 otherwise.
- R11: A symbol sampled with phy_rx_err at 1 is not put into any byte.
- R12: If a frame ends with 1 to 3 counted symbols left over, they are discarded and rx_align_err is 1 with rx_eof.
- R13: phy_rx_err at 1 while phy_carrier_dv is 0 has no effect on the next frame's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | 8 | Byte offered by the MAC |
| tx_valid | input | 1 | tx_data is offered |
| tx_sof | input | 1 | Offered byte starts a frame |
| tx_eof | input | 1 | Offered byte ends a frame |
| tx_ready | output | 1 | Block takes the offered byte at this edge |
| phy_txd | output | 2 | Transmit symbol to the PHY |
| phy_tx_en | output | 1 | Transmit enable to the PHY |
| phy_rxd | input | 2 | Receive symbol from the PHY |
| phy_carrier_dv | input | 1 | Combined carrier sense / receive data valid |
| phy_rx_err | input | 1 | Receive error from the PHY |
| rx_data | output | 8 | Rebuilt received byte |
| rx_valid | output | 1 | rx_data holds a new byte (one clock) |
| rx_sof | output | 1 | With rx_valid: first byte of the frame |
| rx_eof | output | 1 | Received frame has ended (one clock) |
| rx_frame_err | output | 1 | With rx_eof: receive error seen in the frame |
| rx_align_err | output | 1 | With rx_eof: frame ended inside a byte |

## Verification
The assertions assume the MAC keeps tx_valid and its byte stable until tx_ready takes it. They also assume that after reset the PHY lines settle to known levels before the first clock edge. The receive-side checks assume phy_carrier_dv is a clean level that marks one frame per high period. The bench drives every input at the falling clock edge and holds it for whole clocks. It offers each transmit byte until it is taken and brings phy_carrier_dv low between frames for several clocks.

// File: rtl/rmii_dibit_pkg.sv
// Shared definitions for the RMII dibit interface.
// Assumes nothing beyond a synthesizable SystemVerilog flow.
package rmii_dibit_pkg;
    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_state_e;
endpackage

// File: rtl/rmii_tx_serializer.sv
// Turns a handshaked byte stream into transmit symbols, lowest bit pair first.
// Assumes the producer holds a byte stable until in_ready takes it; a frame
// opens only on a byte marked in_sof and runs without gaps.
module rmii_tx_serializer
    import rmii_dibit_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int DIBIT_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BYTE_W-1:0]  in_data,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               in_eof,
    output logic               in_ready,
    output logic [DIBIT_W-1:0] out_dibit,
    output logic               out_en
);
    localparam int SLOTS = BYTE_W / DIBIT_W;
    localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);

    tx_state_e         state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  slot;
    logic              final_q;
    logic              at_end;
    logic              accept;

    assign at_end   = (slot == LAST_SLOT);
    assign in_ready = (state == TX_IDLE) || (at_end && !final_q);
    assign accept   = in_valid && in_ready;

    // Frame sequencing: load, shift one symbol per clock, chain or close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            shreg   <= '0;
            slot    <= '0;
            final_q <= 1'b0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (accept && in_sof) begin
                        shreg   <= in_data;
                        slot    <= '0;
                        final_q <= in_eof;
                        state   <= TX_SHIFT;
                    end
                end
                default: begin
                    if (at_end) begin
                        slot <= '0;
                        if (accept) begin
                            shreg   <= in_data;
                            final_q <= in_eof;
                        end else begin
                            state <= TX_IDLE;
                        end
                    end else begin
                        shreg <= shreg >> DIBIT_W;
                        slot  <= slot + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Symbol output, forced to zero outside a frame.
    always_comb begin
        out_en    = (state == TX_SHIFT);
        out_dibit = out_en ? shreg[DIBIT_W-1:0] : '0;
    end
endmodule

// File: rtl/rmii_rx_assembler.sv
// Rebuilds bytes from receive symbols that arrive with carrier high and no
// error, and reports frame end with error and alignment flags.
// Assumes carrier is a clean level marking one frame per high period.
module rmii_rx_assembler #(
    parameter int BYTE_W  = 8,
    parameter int DIBIT_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIBIT_W-1:0] dibit,
    input  logic               carrier,
    input  logic               err_in,
    output logic [BYTE_W-1:0]  byte_data,
    output logic               byte_valid,
    output logic               byte_sof,
    output logic               frame_end,
    output logic               frame_err,
    output logic               align_err
);
    localparam int SLOTS = BYTE_W / DIBIT_W;
    localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);

    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] acc_next;
    logic [CNT_W-1:0]  slot;
    logic              in_frame;
    logic              err_seen;
    logic              first_pend;
    logic              take;

    assign take     = carrier && !err_in;
    assign acc_next = {dibit, acc[BYTE_W-1:DIBIT_W]};

    // Symbol collection, byte emission and end-of-frame reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc        <= '0;
            slot       <= '0;
            in_frame   <= 1'b0;
            err_seen   <= 1'b0;
            first_pend <= 1'b1;
            byte_data  <= '0;
            byte_valid <= 1'b0;
            byte_sof   <= 1'b0;
            frame_end  <= 1'b0;
            frame_err  <= 1'b0;
            align_err  <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            byte_sof   <= 1'b0;
            frame_end  <= 1'b0;
            frame_err  <= 1'b0;
            align_err  <= 1'b0;
            if (carrier) begin
                in_frame <= 1'b1;
                if (err_in) begin
                    err_seen <= 1'b1;
                end
                if (take) begin
                    acc <= acc_next;
                    if (slot == LAST_SLOT) begin
                        slot       <= '0;
                        byte_data  <= acc_next;
                        byte_valid <= 1'b1;
                        byte_sof   <= first_pend;
                        first_pend <= 1'b0;
                    end else begin
                        slot <= slot + CNT_W'(1);
                    end
                end
            end else if (in_frame) begin
                frame_end  <= 1'b1;
                frame_err  <= err_seen;
                align_err  <= (slot != '0);
                in_frame   <= 1'b0;
                err_seen   <= 1'b0;
                slot       <= '0;
                first_pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rmii_dibit_if.sv
// MAC-side RMII adapter: byte stream to two-bit symbols and back.
// Assumes one continuous 50 MHz reference clock for all ports.
module rmii_dibit_if #(
    parameter int BYTE_W  = 8,
    parameter int DIBIT_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BYTE_W-1:0]  tx_data,
    input  logic               tx_valid,
    input  logic               tx_sof,
    input  logic               tx_eof,
    output logic               tx_ready,
    output logic [DIBIT_W-1:0] phy_txd,
    output logic               phy_tx_en,
    input  logic [DIBIT_W-1:0] phy_rxd,
    input  logic               phy_carrier_dv,
    input  logic               phy_rx_err,
    output logic [BYTE_W-1:0]  rx_data,
    output logic               rx_valid,
    output logic               rx_sof,
    output logic               rx_eof,
    output logic               rx_frame_err,
    output logic               rx_align_err
);
    // Transmit half.
    rmii_tx_serializer #(.BYTE_W(BYTE_W), .DIBIT_W(DIBIT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (tx_data),
        .in_valid  (tx_valid),
        .in_sof    (tx_sof),
        .in_eof    (tx_eof),
        .in_ready  (tx_ready),
        .out_dibit (phy_txd),
        .out_en    (phy_tx_en)
    );

    // Receive half.
    rmii_rx_assembler #(.BYTE_W(BYTE_W), .DIBIT_W(DIBIT_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .dibit      (phy_rxd),
        .carrier    (phy_carrier_dv),
        .err_in     (phy_rx_err),
        .byte_data  (rx_data),
        .byte_valid (rx_valid),
        .byte_sof   (rx_sof),
        .frame_end  (rx_eof),
        .frame_err  (rx_frame_err),
        .align_err  (rx_align_err)
    );
endmodule

// File: rtl/rmii_dibit_if_chk.sv
// Protocol checker for rmii_dibit_if, attached by bind below.
// Assumes the default four symbols per byte.
module rmii_dibit_if_chk #(
    parameter int SLOTS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_ready,
    input logic phy_tx_en,
    input logic phy_carrier_dv,
    input logic rx_valid,
    input logic rx_eof,
    input logic rx_frame_err,
    input logic rx_align_err
);
    localparam int RUN_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [RUN_W-1:0] run_q;
    logic [7:0]       gap_q;

    // Enable run length modulo SLOTS.
    always_ff @(posedge clk) begin
        if (!rst_n || !phy_tx_en) run_q <= '0;
        else if (run_q == RUN_W'(SLOTS - 1)) run_q <= '0;
        else run_q <= run_q + RUN_W'(1);
    end

    // Clocks since the last accepted transmit byte, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || (tx_valid && tx_ready)) gap_q <= '0;
        else if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
    end

    p_whole_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_tx_en) |-> (run_q == '0));

    p_accept_cadence_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && phy_tx_en) |-> (gap_q == 8'(SLOTS - 1)));

    p_byte_apart_from_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_eof));

    p_end_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eof |=> !rx_eof);

    p_end_after_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eof |-> !$past(phy_carrier_dv));

    p_err_with_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |-> rx_eof);

    p_align_with_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_align_err |-> rx_eof);
endmodule

bind rmii_dibit_if rmii_dibit_if_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready),
    .phy_tx_en      (phy_tx_en),
    .phy_carrier_dv (phy_carrier_dv),
    .rx_valid       (rx_valid),
    .rx_eof         (rx_eof),
    .rx_frame_err   (rx_frame_err),
    .rx_align_err   (rx_align_err)
);

// File: tb/sim_rmii_dibit_if.sv
// Directed bench for rmii_dibit_if: one task per scenario.
module sim_rmii_dibit_if;
    localparam time CLK_PERIOD = 20ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0, tx_sof = 1'b0, tx_eof = 1'b0;
    logic       tx_ready;
    logic [1:0] phy_txd;
    logic       phy_tx_en;
    logic [1:0] phy_rxd = '0;
    logic       phy_carrier_dv = 1'b0, phy_rx_err = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_sof, rx_eof, rx_frame_err, rx_align_err;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    logic [1:0] cap [64];
    int  ncap = 0, tx_runs = 0;
    logic prev_en = 1'b0;
    logic [7:0] rbytes [16];
    bit  rsof [16];
    int  nrb = 0, neof = 0, eof_cyc = 0, fall_cyc = 0;
    bit  last_err = 0, last_align = 0;
    int  acc_cyc [16];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rmii_dibit_if u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_eof(tx_eof),
        .tx_ready(tx_ready), .phy_txd(phy_txd), .phy_tx_en(phy_tx_en),
        .phy_rxd(phy_rxd), .phy_carrier_dv(phy_carrier_dv), .phy_rx_err(phy_rx_err),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_frame_err(rx_frame_err), .rx_align_err(rx_align_err)
    );

    // Output monitor, sampling at the falling edge.
    always @(negedge clk) begin
        if (phy_tx_en) begin
            if (ncap < 64) cap[ncap] = phy_txd;
            ncap++;
            if (!prev_en) tx_runs++;
        end else if (phy_txd != 2'b00) begin
            check(0, "R5", int'(phy_txd), 0);
        end
        prev_en = phy_tx_en;
        if (rx_valid) begin
            if (nrb < 16) begin rbytes[nrb] = rx_data; rsof[nrb] = rx_sof; end
            nrb++;
        end
        if (rx_eof) begin
            neof++; eof_cyc = cyc; last_err = rx_frame_err; last_align = rx_align_err;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic clear_mon();
        ncap = 0; tx_runs = 0; nrb = 0; neof = 0;
    endtask

    function automatic logic [7:0] tx_byte(input int i);
        return {cap[4*i+3], cap[4*i+2], cap[4*i+1], cap[4*i]};
    endfunction

    // Offers n bytes; the last carries tx_eof if mark_end is set.
    task automatic tx_send(input int n, input logic [7:0] base, input bit mark_end);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tx_valid = 1'b1; tx_data = base + 8'(i * 37);
            tx_sof = (i == 0); tx_eof = mark_end && (i == n - 1);
            while (!tx_ready) @(negedge clk);
            @(posedge clk);
            acc_cyc[i] = cyc;
        end
        @(negedge clk);
        tx_valid = 1'b0; tx_sof = 1'b0; tx_eof = 1'b0;
        repeat (4 * n + 4) @(negedge clk);
    endtask

    task automatic rx_sym(input bit dv, input logic [1:0] d, input bit er);
        @(negedge clk);
        phy_carrier_dv = dv; phy_rxd = d; phy_rx_err = er;
    endtask

    task automatic rx_byte(input logic [7:0] b);
        for (int k = 0; k < 4; k++) rx_sym(1'b1, b[2*k +: 2], 1'b0);
    endtask

    task automatic rx_close();
        rx_sym(1'b0, 2'b00, 1'b0);
        fall_cyc = cyc;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(phy_tx_en == 0 && phy_txd == 0, "R1 tx outputs", int'({phy_tx_en, phy_txd}), 0);
        check(tx_ready == 1, "R1 tx_ready", int'(tx_ready), 1);
        check({rx_valid, rx_sof, rx_eof, rx_frame_err, rx_align_err} == 0, "R1 rx flags",
              int'({rx_valid, rx_sof, rx_eof, rx_frame_err, rx_align_err}), 0);
    endtask

    task automatic t_tx_frame();
        clear_mon();
        tx_send(3, 8'hB4, 1'b1);
        check(ncap == 12, "R3 enable length", ncap, 12);
        check(tx_runs == 1, "R3 contiguous enable", tx_runs, 1);
        for (int i = 0; i < 3; i++)
            check(tx_byte(i) == 8'hB4 + 8'(i * 37), "R2 symbol order",
                  int'(tx_byte(i)), int'(8'hB4 + 8'(i * 37)));
        check(acc_cyc[1] - acc_cyc[0] == 4, "R4 cadence 0-1", acc_cyc[1] - acc_cyc[0], 4);
        check(acc_cyc[2] - acc_cyc[1] == 4, "R4 cadence 1-2", acc_cyc[2] - acc_cyc[1], 4);
        check(tx_ready == 1, "R4 ready when idle", int'(tx_ready), 1);
    endtask

    task automatic t_tx_no_start();
        clear_mon();
        @(negedge clk);
        tx_valid = 1'b1; tx_sof = 1'b0; tx_data = 8'hFF;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (6) @(negedge clk);
        check(ncap == 0 && tx_runs == 0, "R6 no frame without start", ncap, 0);
        check(phy_txd == 0, "R5 idle symbol", int'(phy_txd), 0);
    endtask

    task automatic t_tx_underrun();
        clear_mon();
        tx_send(2, 8'h3C, 1'b0);
        check(ncap == 8, "R7 underrun length", ncap, 8);
        check(tx_byte(1) == 8'h3C + 8'd37, "R7 last byte intact", int'(tx_byte(1)), int'(8'h3C + 8'd37));
    endtask

    task automatic t_rx_good();
        clear_mon();
        rx_byte(8'hA5); rx_byte(8'h3C);
        rx_close();
        check(nrb == 2, "R8 byte count", nrb, 2);
        check(rbytes[0] == 8'hA5 && rbytes[1] == 8'h3C, "R8 byte values",
              int'({rbytes[0], rbytes[1]}), 16'hA53C);
        check(rsof[0] == 1 && rsof[1] == 0, "R8 start flag", int'({rsof[0], rsof[1]}), 2);
        check(neof == 1 && eof_cyc == fall_cyc + 1, "R9 end timing", eof_cyc - fall_cyc, 1);
        check(last_err == 0 && last_align == 0, "R10 clean frame flags",
              int'({last_err, last_align}), 0);
    endtask

    task automatic t_rx_error();
        clear_mon();
        rx_sym(1, 2'b10, 0); rx_sym(1, 2'b01, 0);
        rx_sym(1, 2'b11, 1);
        rx_sym(1, 2'b01, 0); rx_sym(1, 2'b10, 0);
        rx_byte(8'h5A);
        rx_close();
        check(last_err == 1, "R10 error flag", int'(last_err), 1);
        check(nrb == 2 && rbytes[0] == 8'h96 && rbytes[1] == 8'h5A, "R11 errored symbol skipped",
              int'(rbytes[0]), 8'h96);
        check(last_align == 0, "R11 alignment kept", int'(last_align), 0);
    endtask

    task automatic t_rx_partial();
        clear_mon();
        rx_byte(8'h81);
        rx_sym(1, 2'b11, 0); rx_sym(1, 2'b00, 0);
        rx_close();
        check(nrb == 1 && rbytes[0] == 8'h81, "R12 whole byte only", nrb, 1);
        check(neof == 1 && last_align == 1, "R12 alignment flag", int'(last_align), 1);
    endtask

    task automatic t_rx_idle_error();
        clear_mon();
        rx_sym(0, 2'b11, 1); rx_sym(0, 2'b11, 1); rx_sym(0, 2'b00, 0);
        rx_byte(8'h7E);
        rx_close();
        check(nrb == 1 && rbytes[0] == 8'h7E, "R13 next frame data", int'(rbytes[0]), 8'h7E);
        check(last_err == 0, "R13 no carried error", int'(last_err), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_tx_frame();
        t_tx_no_start();
        t_tx_underrun();
        t_rx_good();
        t_rx_error();
        t_rx_partial();
        t_rx_idle_error();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", cyc, 0);
            finish_run();
        end
    end
endmodule